// File: doc/BRIEF.md
# ADC Result Code Formatter

This block sits behind a converter core and turns each raw signed difference sample into a 10-bit output word. A small registered mode word decides how the sample is read. A ground-referenced (single-ended) channel or a differential pair is chosen by one bit. A second bit asks for either straight-binary or two's-complement coding. A third bit names the channel. A serial control port outside this block loads the mode word through a write strobe and three data bits.

Ground-referenced channels always use straight-binary coding, whatever the coding bit says. In straight-binary coding the span is zero to the full reference: negative samples give code zero, and samples above the top code saturate. In two's-complement coding the span is plus or minus half the reference: the sample is halved and then saturated to the signed 10-bit range. The input sample is signed and scaled so that +1023 is the full reference. Each result is registered together with the mode that produced it.

Top module: `adc_code_formatter`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` is 0, `res_code` is 0, and the reported mode is single-ended (`res_single`=1), straight-binary (`res_bipolar`=0), channel 0 (`res_chan`=0).
- R2: `res_valid` is 1 in exactly the clock after a clock in which `smp_valid` is 1, and 0 otherwise.
- R3: While no sample is accepted, `res_code` and the reported mode hold their last values.
- R4: When the single-ended bit is 1, the result uses straight-binary coding and `res_bipolar` reads 0, even when the stored coding bit is 1.
- R5: In straight-binary coding, a sample from 0 to 1023 gives `res_code` equal to the sample.
- R6: In straight-binary coding, any negative sample gives `res_code` = 0.
- R7: In straight-binary coding, a sample above 1023 gives `res_code` = 1023.
- R8: In two's-complement coding (single-ended bit 0, coding bit 1), `res_code` is the sample shifted right by one with sign kept (rounding toward minus infinity), written as 10-bit two's complement (bit 9 is the sign).
- R9: In two's-complement coding, a halved value above +511 gives 511 (0x1FF), and one below -512 gives -512 (0x200).
- R10: A mode write takes effect for the first sample after the strobe's clock; a sample in the same clock as the write uses the previous mode.
- R11: `res_single`, `res_bipolar` and `res_chan` report the effective mode that produced the current `res_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_single | input | 1 | New single-ended select (1 = ground-referenced) |
| cfg_bipolar | input | 1 | New coding select (1 = two's complement) |
| cfg_chan | input | 1 | New channel select |
| smp_valid | input | 1 | Sample strobe |
| smp_diff | input | IN_W | Signed sample, +1023 = full reference |
| res_valid | output | 1 | Result strobe, one clock after the sample |
| res_code | output | OUT_W | Formatted result word |
| res_single | output | 1 | Effective single-ended flag of the result |
| res_bipolar | output | 1 | Effective coding flag of the result |
| res_chan | output | 1 | Channel of the result |

## Verification
The bench builds the block with a 12-bit sample and the default 10-bit result word. A sample one bit wider than the default lets values up to 2047 and down to -2048 reach the design. This brings the straight-binary saturation at 1023 and both two's-complement limits within reach. With the default 11-bit input neither can be reached.

// File: rtl/adcfmt_pkg.sv
// Package: shared mode type and reset value for the result code formatter.
// Assumes single-bit fields; field order inside the struct is internal only.
package adcfmt_pkg;

    typedef struct packed {
        logic single;   // 1 = ground-referenced channel
        logic bipolar;  // 1 = two's-complement coding requested
        logic chan;     // channel select
    } fmt_mode_t;

    localparam fmt_mode_t MODE_RESET = '{single: 1'b1, bipolar: 1'b0, chan: 1'b0};

endpackage

// File: rtl/adcfmt_cfg_reg.sv
// Module: holds the mode word written by the control port and resolves the
// effective mode (a ground-referenced channel forces straight-binary coding).
// Assumes the write strobe is a single-clock pulse in this clock domain.
module adcfmt_cfg_reg
    import adcfmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  fmt_mode_t wr_mode,
    output fmt_mode_t eff_mode
);

    fmt_mode_t stored_q;

    // Capture a new mode word on the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_q <= MODE_RESET;
        end else if (wr) begin
            stored_q <= wr_mode;
        end
    end

    // Resolve the coding actually applied; the stored coding bit is kept.
    always_comb begin
        eff_mode         = stored_q;
        eff_mode.bipolar = stored_q.bipolar & ~stored_q.single;
    end

endmodule

// File: rtl/adcfmt_coder.sv
// Module: combinational range scaling, clamping and code formatting.
// Assumes IN_W <= 31 and OUT_W >= 2; +((1<<OUT_W)-1) is the full reference.
module adcfmt_coder #(
    parameter int IN_W  = 11,
    parameter int OUT_W = 10
) (
    input  logic signed [IN_W-1:0]  diff,
    input  logic                    bipolar,
    output logic        [OUT_W-1:0] code
);

    localparam int EXT_W = 32;
    localparam int UMAX  = (1 << OUT_W) - 1;
    localparam int BMAX  = (1 << (OUT_W - 1)) - 1;
    localparam int BMIN  = -(1 << (OUT_W - 1));

    logic signed [EXT_W-1:0] dx;
    logic signed [EXT_W-1:0] half;
    logic        [OUT_W-1:0] uni_code;
    logic        [OUT_W-1:0] bip_code;

    assign dx   = {{(EXT_W - IN_W){diff[IN_W-1]}}, diff};
    assign half = dx >>> 1;

    // Straight binary: clamp negatives to zero, saturate at the top code.
    always_comb begin
        if (dx < 0) begin
            uni_code = '0;
        end else if (dx > UMAX) begin
            uni_code = UMAX[OUT_W-1:0];
        end else begin
            uni_code = dx[OUT_W-1:0];
        end
    end

    // Two's complement: halve the span, then saturate to the signed range.
    always_comb begin
        if (half > BMAX) begin
            bip_code = BMAX[OUT_W-1:0];
        end else if (half < BMIN) begin
            bip_code = BMIN[OUT_W-1:0];
        end else begin
            bip_code = half[OUT_W-1:0];
        end
    end

    // Pick the coding chosen by the effective mode.
    assign code = bipolar ? bip_code : uni_code;

endmodule

// File: rtl/adcfmt_out_reg.sv
// Module: result register; loads code and mode tag on each accepted sample
// and holds them otherwise. The valid flag follows the sample strobe by one clock.
module adcfmt_out_reg
    import adcfmt_pkg::*;
#(
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OUT_W-1:0] code_in,
    input  fmt_mode_t        mode_in,
    output logic             valid_q,
    output logic [OUT_W-1:0] code_q,
    output fmt_mode_t        mode_q
);

    // Register the result word, its mode tag and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            code_q  <= '0;
            mode_q  <= MODE_RESET;
        end else begin
            valid_q <= load;
            if (load) begin
                code_q <= code_in;
                mode_q <= mode_in;
            end
        end
    end

endmodule

// File: rtl/adc_code_formatter.sv
// Module: top of the result code formatter. A sample is coded with the mode
// held in the clock it arrives; a write in that same clock applies to later samples.
module adc_code_formatter
    import adcfmt_pkg::*;
#(
    parameter int IN_W  = 11,
    parameter int OUT_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic                    cfg_single,
    input  logic                    cfg_bipolar,
    input  logic                    cfg_chan,
    input  logic                    smp_valid,
    input  logic signed [IN_W-1:0]  smp_diff,
    output logic                    res_valid,
    output logic        [OUT_W-1:0] res_code,
    output logic                    res_single,
    output logic                    res_bipolar,
    output logic                    res_chan
);

    fmt_mode_t        wr_mode;
    fmt_mode_t        eff_mode;
    fmt_mode_t        res_mode;
    logic [OUT_W-1:0] next_code;

    // Gather the write data into the mode type.
    always_comb begin
        wr_mode.single  = cfg_single;
        wr_mode.bipolar = cfg_bipolar;
        wr_mode.chan    = cfg_chan;
    end

    adcfmt_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wr_mode  (wr_mode),
        .eff_mode (eff_mode)
    );

    adcfmt_coder #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W)
    ) u_coder (
        .diff    (smp_diff),
        .bipolar (eff_mode.bipolar),
        .code    (next_code)
    );

    adcfmt_out_reg #(
        .OUT_W (OUT_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (smp_valid),
        .code_in (next_code),
        .mode_in (eff_mode),
        .valid_q (res_valid),
        .code_q  (res_code),
        .mode_q  (res_mode)
    );

    assign res_single  = res_mode.single;
    assign res_bipolar = res_mode.bipolar;
    assign res_chan    = res_mode.chan;

endmodule

// File: rtl/adcfmt_checker.sv
// Module: property checker for the result code formatter, bound to the top.
module adcfmt_checker
    import adcfmt_pkg::*;
#(
    parameter int IN_W  = 11,
    parameter int OUT_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_wr,
    input logic                    cfg_single,
    input logic                    smp_valid,
    input logic signed [IN_W-1:0]  smp_diff,
    input logic                    res_valid,
    input logic        [OUT_W-1:0] res_code,
    input logic                    res_single,
    input logic                    res_bipolar,
    input logic                    res_chan,
    input fmt_mode_t               eff_mode
);

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> res_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !res_valid);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(res_code) && $stable(res_single) && $stable(res_chan));

    p_single_unip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_single |-> !res_bipolar);

    p_unip_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !eff_mode.bipolar && smp_diff[IN_W-1] |=> res_code == '0);

    p_bip_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && eff_mode.bipolar |=> res_code[OUT_W-1] == $past(smp_diff[IN_W-1]));

    p_cfg_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> eff_mode.single == $past(cfg_single));

    p_mode_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> res_single == $past(eff_mode.single) && res_chan == $past(eff_mode.chan));

endmodule

bind adc_code_formatter adcfmt_checker #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_single  (cfg_single),
    .smp_valid   (smp_valid),
    .smp_diff    (smp_diff),
    .res_valid   (res_valid),
    .res_code    (res_code),
    .res_single  (res_single),
    .res_bipolar (res_bipolar),
    .res_chan    (res_chan),
    .eff_mode    (eff_mode)
);

// File: tb/adc_code_formatter_bench.sv
// Bench: directed corners plus seeded random samples and mode writes,
// compared against a model built from the requirements.
module adc_code_formatter_bench;

    localparam int IN_W  = 12;
    localparam int OUT_W = 10;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cfg_wr = 1'b0;
    logic                    cfg_single = 1'b0;
    logic                    cfg_bipolar = 1'b0;
    logic                    cfg_chan = 1'b0;
    logic                    smp_valid = 1'b0;
    logic signed [IN_W-1:0]  smp_diff = '0;
    logic                    res_valid;
    logic        [OUT_W-1:0] res_code;
    logic                    res_single;
    logic                    res_bipolar;
    logic                    res_chan;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  m_single = 1'b1;
    bit  m_bip    = 1'b0;
    bit  m_chan   = 1'b0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    adc_code_formatter #(.IN_W(IN_W), .OUT_W(OUT_W)) u_adc_code_formatter (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_single  (cfg_single),
        .cfg_bipolar (cfg_bipolar),
        .cfg_chan    (cfg_chan),
        .smp_valid   (smp_valid),
        .smp_diff    (smp_diff),
        .res_valid   (res_valid),
        .res_code    (res_code),
        .res_single  (res_single),
        .res_bipolar (res_bipolar),
        .res_chan    (res_chan)
    );

    function automatic int exp_code(int x, bit single, bit bip);
        int h;
        if (single || !bip) begin
            if (x < 0)    return 0;
            if (x > 1023) return 1023;
            return x;
        end
        h = x >>> 1;
        if (h > 511)  h = 511;
        if (h < -512) h = -512;
        return h & 32'h3FF;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_mode(bit s, bit b, bit c);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_single = s; cfg_bipolar = b; cfg_chan = c;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_single = s; m_bip = b; m_chan = c;
    endtask

    // One sample; checks code, valid and mode tag one clock later.
    task automatic sample(int x, string req);
        int e;
        bit eb;
        e  = exp_code(x, m_single, m_bip);
        eb = m_bip & ~m_single;
        @(negedge clk);
        smp_valid = 1'b1; smp_diff = x[IN_W-1:0];
        @(negedge clk);
        smp_valid = 1'b0;
        check(res_valid == 1'b1, "R2", int'(res_valid), 1);
        check(int'(res_code) == e, req, int'(res_code), e);
        check(res_single == m_single && res_bipolar == eb && res_chan == m_chan,
              "R11", {res_single, res_bipolar, res_chan}, {m_single, eb, m_chan});
    endtask

    initial begin
        int x;
        int e;
        int held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(res_valid == 1'b0 && res_code == '0, "R1", int'(res_code), 0);
        check(res_single && !res_bipolar && !res_chan, "R1",
              {res_single, res_bipolar, res_chan}, 3'b100);

        // R5 / R6 / R7 in ground-referenced mode
        sample(0, "R5");
        sample(1023, "R5");
        sample(517, "R5");
        sample(1024, "R7");
        sample(2047, "R7");
        sample(-1, "R6");
        sample(-2048, "R6");

        // R4: coding bit set but single-ended still straight binary
        write_mode(1'b1, 1'b1, 1'b1);
        sample(-5, "R4");
        sample(700, "R4");
        check(res_bipolar == 1'b0, "R4", int'(res_bipolar), 0);

        // R6 / R7 in differential straight-binary
        write_mode(1'b0, 1'b0, 1'b0);
        sample(-300, "R6");
        sample(1500, "R7");
        sample(1023, "R5");

        // R8 / R9 in two's complement
        write_mode(1'b0, 1'b1, 1'b1);
        sample(3, "R8");
        sample(-1, "R8");
        sample(-3, "R8");
        sample(1022, "R8");
        sample(1023, "R9");
        sample(1024, "R9");
        sample(2047, "R9");
        sample(-1024, "R8");
        sample(-1025, "R9");
        sample(-2048, "R9");

        // R3: hold while idle with noise on the sample input
        held = int'(res_code);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            smp_diff = IN_W'($urandom);
            check(res_valid == 1'b0, "R2", int'(res_valid), 0);
            check(int'(res_code) == held, "R3", int'(res_code), held);
        end

        // R10: write and sample in the same clock use the old mode
        @(negedge clk);
        cfg_wr = 1'b1; cfg_single = 1'b0; cfg_bipolar = 1'b0; cfg_chan = 1'b0;
        smp_valid = 1'b1; smp_diff = -12'sd400;
        e = exp_code(-400, 1'b0, 1'b1);
        @(negedge clk);
        cfg_wr = 1'b0; smp_valid = 1'b0;
        check(int'(res_code) == e, "R10", int'(res_code), e);
        check(res_bipolar == 1'b1 && res_chan == 1'b1, "R10",
              {res_bipolar, res_chan}, 2'b11);
        m_single = 1'b0; m_bip = 1'b0; m_chan = 1'b0;
        sample(-400, "R10");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0)
                write_mode(1'($urandom), 1'($urandom), 1'($urandom));
            x = int'($urandom_range(0, 4095)) - 2048;
            if (m_single || !m_bip) sample(x, (x < 0) ? "R6" : (x > 1023) ? "R7" : "R5");
            else sample(x, "R8");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule